// File: doc/BRIEF.md
# Cross-Pipe Raster Resynchronisation Trigger

This block lets one display timing generator realign its raster to the vertical sync of a neighbouring pipe. Each pipe's vertical sync arrives asynchronously; the block brings every one of them into the local clock domain and picks one with a select input. It watches that signal for a rising edge, a falling edge, or either, as enabled.

When it sees the selected edge, it requests a realignment from an external horizontal/vertical counter pair. Two ways of doing this are offered. In count-now mode, a one-cycle pulse tells the counters to load their end-of-frame totals at once, so that both wrap to zero on the following clock. In next-line mode, the request is held and released as a one-cycle forced vertical sync at the next line start that the counter pair reports.

Each mode keeps its own sticky "occurred" flag, which is cleared by a write-one pulse. A combined status is the OR of the two flags. A rising edge is the usual choice for an active-high source sync and a falling edge for an active-low one.

Top module: `xpipe_resync_trig`

## Requirements
- R1: After reset, force_count, force_vsync, count_occurred, line_occurred and reset_occurred are all 0.
- R2: Only the vertical sync of the pipe whose index equals pipe_sel can cause a trigger. Edges on every other pipe have no effect on any output.
- R3: rise_en enables detection of a 0-to-1 transition and fall_en enables detection of a 1-to-0 transition. With both set, either transition triggers. With neither set, nothing triggers.
- R4: With line_mode=0, a detected edge produces exactly one cycle of force_count. A source sync that changes before clock edge k makes force_count high in the cycle after edge k+2 (two synchroniser stages plus one edge register).
- R5: With line_mode=1, a detected edge arms a pending request and produces no force_count. The request fires as one cycle of force_vsync in the cycle after the first clock edge where line_start is high. A line_start that coincides with the cycle in which the edge is detected does not release it.
- R6: An edge detected while a next-line request is pending, or in the cycle it fires, merges into that request. Any number of such edges yields a single force_vsync.
- R7: count_occurred is set on the same edge as force_count, and line_occurred is set on the same edge as force_vsync. Both stay set until cleared. reset_occurred is the OR of the two flags.
- R8: A high clr_count_flag (or clr_line_flag) for one cycle clears count_occurred (or line_occurred) on the next edge. A new occurrence in that same cycle wins over the clear.
- R9: While trig_en is 0, no edge is detected and any pending next-line request is dropped. The sticky flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_vsync | input | NUM_PIPES | Asynchronous vertical sync of each pipe |
| pipe_sel | input | $clog2(NUM_PIPES) | Index of the source pipe |
| trig_en | input | 1 | Trigger enable; low disables detection and drops pending requests |
| rise_en | input | 1 | Detect rising edges of the source |
| fall_en | input | 1 | Detect falling edges of the source |
| line_mode | input | 1 | 0 = count-now, 1 = next-line forced vsync |
| line_start | input | 1 | Start-of-line strobe from the external counter pair |
| clr_count_flag | input | 1 | Write-one clear of count_occurred |
| clr_line_flag | input | 1 | Write-one clear of line_occurred |
| force_count | output | 1 | One-cycle request to load horizontal and vertical totals |
| force_vsync | output | 1 | One-cycle forced vertical sync at a line start |
| count_occurred | output | 1 | Sticky flag for count-now triggers |
| line_occurred | output | 1 | Sticky flag for next-line triggers |
| reset_occurred | output | 1 | OR of the two sticky flags |

## Verification
A source sync change made before a clock edge reaches force_count after the third edge, counting that edge. force_vsync follows one edge after the first cycle in which a pending request sees line_start. The sticky flags rise on the same edge as their force, and a clear takes effect one edge after the clear pulse. All stimulus changes on falling clock edges. Every output is compared on falling edges against a cycle model built from the requirements, and the directed cases sample at exactly those counted edges.

// File: rtl/xrt_pkg.sv
package xrt_pkg;

  typedef enum logic {
    MODE_COUNT_NOW = 1'b0,
    MODE_NEXT_LINE = 1'b1
  } xrt_mode_e;

  // Edge qualification: current and previous synchronised level against enables.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic rise_ok, input logic fall_ok);
    return (rise_ok & cur & ~prev) | (fall_ok & ~cur & prev);
  endfunction

  // Next-line pending state: armed by a hit, consumed when it fires.
  function automatic logic pend_next(input logic active, input logic pend,
                                     input logic hit, input logic fire);
    return active & (pend | hit) & ~fire;
  endfunction

endpackage

// File: rtl/xrt_pipe_sync.sv
module xrt_pipe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic prev_level
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      prev_level <= 1'b0;
    end else begin
      sr         <= {sr[STAGES-2:0], async_in};
      prev_level <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
endmodule

// File: rtl/xrt_edge_sel.sv
module xrt_edge_sel #(
  parameter int NUM_PIPES = 4,
  localparam int SEL_W = $clog2(NUM_PIPES)
) (
  input  logic [NUM_PIPES-1:0] level,
  input  logic [NUM_PIPES-1:0] prev_level,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 trig_en,
  input  logic                 rise_en,
  input  logic                 fall_en,
  output logic                 trig
);
  import xrt_pkg::*;

  always_comb begin
    trig = 1'b0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (sel == SEL_W'(p))
        trig = trig_en & edge_hit(level[p], prev_level[p], rise_en, fall_en);
    end
  end
endmodule

// File: rtl/xrt_force_ctl.sv
module xrt_force_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic trig_en,
  input  logic line_mode,
  input  logic line_start,
  input  logic clr_count,
  input  logic clr_line,
  output logic force_count,
  output logic force_vsync,
  output logic count_flag,
  output logic line_flag
);
  import xrt_pkg::*;

  logic      pending;
  logic      fire_count;
  logic      arm_line;
  logic      fire_line;
  logic      line_active;
  xrt_mode_e mode;

  assign mode        = xrt_mode_e'(line_mode);
  assign line_active = trig_en & (mode == MODE_NEXT_LINE);
  assign fire_count  = trig & (mode == MODE_COUNT_NOW);
  assign arm_line    = trig & (mode == MODE_NEXT_LINE);
  assign fire_line   = pending & line_start & line_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      force_count <= 1'b0;
      force_vsync <= 1'b0;
      count_flag  <= 1'b0;
      line_flag   <= 1'b0;
    end else begin
      pending     <= pend_next(line_active, pending, arm_line, fire_line);
      force_count <= fire_count;
      force_vsync <= fire_line;
      count_flag  <= fire_count | (count_flag & ~clr_count);
      line_flag   <= fire_line | (line_flag & ~clr_line);
    end
  end

  AST_COUNT_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    force_count |-> !$past(line_mode)); // R4
  AST_VSYNC_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    force_vsync |-> $past(line_start) && $past(pending)); // R5
  AST_VSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    force_vsync |-> !pending); // R6
  AST_COUNT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_flag) |-> force_count); // R7
  AST_LINE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_flag) |-> force_vsync); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_flag && !clr_count) |=> count_flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_line && !fire_line) |=> !line_flag); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !force_count && !force_vsync && !pending); // R9
endmodule

// File: rtl/xpipe_resync_trig.sv
module xpipe_resync_trig #(
  parameter int NUM_PIPES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PIPES-1:0]         src_vsync,
  input  logic [$clog2(NUM_PIPES)-1:0] pipe_sel,
  input  logic                         trig_en,
  input  logic                         rise_en,
  input  logic                         fall_en,
  input  logic                         line_mode,
  input  logic                         line_start,
  input  logic                         clr_count_flag,
  input  logic                         clr_line_flag,
  output logic                         force_count,
  output logic                         force_vsync,
  output logic                         count_occurred,
  output logic                         line_occurred,
  output logic                         reset_occurred
);
  logic [NUM_PIPES-1:0] sync_level;
  logic [NUM_PIPES-1:0] sync_prev;
  logic                 trig;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    xrt_pipe_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (src_vsync[p]),
      .level      (sync_level[p]),
      .prev_level (sync_prev[p])
    );
  end

  xrt_edge_sel #(.NUM_PIPES(NUM_PIPES)) i_sel (
    .level      (sync_level),
    .prev_level (sync_prev),
    .sel        (pipe_sel),
    .trig_en    (trig_en),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .trig       (trig)
  );

  xrt_force_ctl i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .trig_en     (trig_en),
    .line_mode   (line_mode),
    .line_start  (line_start),
    .clr_count   (clr_count_flag),
    .clr_line    (clr_line_flag),
    .force_count (force_count),
    .force_vsync (force_vsync),
    .count_flag  (count_occurred),
    .line_flag   (line_occurred)
  );

  assign reset_occurred = count_occurred | line_occurred;

  AST_NO_DUAL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({force_count, force_vsync})); // R5
  AST_STATUS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (force_count || force_vsync) |-> reset_occurred); // R7
endmodule

// File: tb/test_xpipe_resync_trig.sv
module test_xpipe_resync_trig;
  localparam int N  = 4;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] vs = '0;
  logic [SW-1:0] sel = '0;
  logic en = 1'b0, ren = 1'b0, fen = 1'b0, lmode = 1'b0, lstart = 1'b0;
  logic clr_c = 1'b0, clr_l = 1'b0;
  logic fc, fv, cf, lf, ro;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  xpipe_resync_trig #(.NUM_PIPES(N)) i_xpipe_resync_trig (
    .clk(clk), .rst_n(rst_n), .src_vsync(vs), .pipe_sel(sel), .trig_en(en),
    .rise_en(ren), .fall_en(fen), .line_mode(lmode), .line_start(lstart),
    .clr_count_flag(clr_c), .clr_line_flag(clr_l), .force_count(fc),
    .force_vsync(fv), .count_occurred(cf), .line_occurred(lf), .reset_occurred(ro)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle model derived from the requirements.
  logic [N-1:0] h1, h2, h3;
  logic m_pend, m_fc, m_fv, m_cf, m_lf;
  logic hit_m, fire_m;

  function automatic logic sel_edge(input logic [N-1:0] cur, input logic [N-1:0] old,
                                    input logic [SW-1:0] s, input logic r, input logic f);
    logic c = cur[s];
    logic o = old[s];
    if (r && c && !o) return 1'b1;
    if (f && !c && o) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= '0; h2 <= '0; h3 <= '0;
      m_pend <= 0; m_fc <= 0; m_fv <= 0; m_cf <= 0; m_lf <= 0;
    end else begin
      hit_m  = en && sel_edge(h2, h3, sel, ren, fen);
      fire_m = en && lmode && m_pend && lstart;
      h1 <= vs; h2 <= h1; h3 <= h2;
      m_fc <= hit_m && !lmode;
      m_fv <= fire_m;
      m_pend <= (en && lmode) ? ((m_pend || hit_m) && !fire_m) : 1'b0;
      m_cf <= (hit_m && !lmode) || (m_cf && !clr_c);
      m_lf <= fire_m || (m_lf && !clr_l);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(fc == m_fc, "R4", "force_count vs model", fc, m_fc);
      chk(fv == m_fv, "R5", "force_vsync vs model", fv, m_fv);
      chk(cf == m_cf, "R7", "count_occurred vs model", cf, m_cf);
      chk(lf == m_lf, "R7", "line_occurred vs model", lf, m_lf);
      chk(ro == (m_cf | m_lf), "R7", "reset_occurred OR", ro, m_cf | m_lf);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int nfc, output int nfv);
    nfc = 0; nfv = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nfc += int'(fc);
      nfv += int'(fv);
    end
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(1'b0, "WATCHDOG", "run did not finish", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int a, b;
    void'($urandom(32'h5eed1234));
    step(3);
    chk(!fc && !fv && !cf && !lf && !ro, "R1", "outputs in reset", {fc, fv, cf, lf, ro}, 0);
    rst_n = 1'b1;
    step(1);
    chk(!fc && !fv && !cf && !lf && !ro, "R1", "outputs after reset", {fc, fv, cf, lf, ro}, 0);
    cmp_on = 1'b1;

    // R4 exact latency, count-now, rising edge on pipe 1
    en = 1; ren = 1; fen = 0; lmode = 0; sel = 2'd1;
    step(4);
    vs[1] = 1'b1;
    step(1); chk(fc == 0, "R4", "force_count after edge 1", fc, 0);
    step(1); chk(fc == 0, "R4", "force_count after edge 2", fc, 0);
    step(1); chk(fc == 1, "R4", "force_count after edge 3", fc, 1);
    chk(cf == 1, "R7", "count_occurred with force", cf, 1);
    step(1); chk(fc == 0, "R4", "force_count single cycle", fc, 0);

    // R2: edges on unselected pipes ignored
    sel = 2'd2;
    step(4);
    vs[0] = 1'b1; vs[3] = 1'b1;
    count_pulses(8, a, b);
    chk(a == 0, "R2", "pulses from unselected pipes", a, 0);
    vs[2] = 1'b1;
    count_pulses(8, a, b);
    chk(a == 1, "R2", "pulse from selected pipe", a, 1);

    // R3: falling only
    ren = 0; fen = 1; vs[2] = 1'b0;
    count_pulses(8, a, b);
    chk(a == 1, "R3", "falling edge detected", a, 1);
    vs[2] = 1'b1;
    count_pulses(8, a, b);
    chk(a == 0, "R3", "rising edge ignored with fall only", a, 0);
    ren = 0; fen = 0; vs[2] = 1'b0;
    count_pulses(8, a, b);
    chk(a == 0, "R3", "no enables no trigger", a, 0);

    // R8: clear count flag
    @(negedge clk); clr_c = 1'b1;
    @(negedge clk); clr_c = 1'b0;
    chk(cf == 0, "R8", "count_occurred cleared", cf, 0);
    chk(ro == 0, "R8", "reset_occurred after clear", ro, 0);

    // R5: next-line mode waits for line_start
    lmode = 1; ren = 1; fen = 0;
    step(2);
    vs[2] = 1'b1;
    count_pulses(8, a, b);
    chk(b == 0 && a == 0, "R5", "no force before line_start", b, 0);
    lstart = 1'b1;
    @(negedge clk); lstart = 1'b0;
    chk(fv == 1, "R5", "force_vsync after line_start", fv, 1);
    chk(lf == 1, "R7", "line_occurred set", lf, 1);
    step(1);
    chk(fv == 0, "R5", "force_vsync single cycle", fv, 0);

    // R6: several edges merge into one request
    for (int k = 0; k < 3; k++) begin
      vs[2] = 1'b0; step(4); vs[2] = 1'b1; step(4);
    end
    lstart = 1'b1;
    count_pulses(6, a, b);
    lstart = 1'b0;
    chk(b == 1, "R6", "merged force_vsync count", b, 1);

    // R9: disabled trigger drops pending, keeps flags
    vs[2] = 1'b0; step(4); vs[2] = 1'b1; step(5);
    en = 1'b0; step(1); en = 1'b1;
    lstart = 1'b1;
    count_pulses(4, a, b);
    lstart = 1'b0;
    chk(b == 0, "R9", "pending dropped on disable", b, 0);
    chk(lf == 1, "R9", "line flag kept while disabled", lf, 1);
    en = 1'b0; lmode = 0; vs[2] = 1'b0; step(4); vs[2] = 1'b1;
    count_pulses(8, a, b);
    chk(a == 0, "R9", "no trigger while disabled", a, 0);
    en = 1'b1;

    // Random phase, checked each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int p = 0; p < N; p++)
        if ($urandom_range(0, 5) == 0) vs[p] = ~vs[p];
      lstart = ($urandom_range(0, 7) == 0);
      clr_c  = ($urandom_range(0, 15) == 0);
      clr_l  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 40) == 0) sel = SW'($urandom_range(0, N - 1));
      if ($urandom_range(0, 60) == 0) lmode = ~lmode;
      if ($urandom_range(0, 50) == 0) ren = ~ren;
      if ($urandom_range(0, 50) == 0) fen = ~fen;
      en = ($urandom_range(0, 30) != 0);
    end
    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule